// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block generates pulse-width modulated outputs on several independent channels. Each channel divides the system clock by a power of two to make a tick. It counts ticks from zero across a programmable period and drives its output from a comparison against a programmable duty count. Every period opens at the inactive level. The output stays inactive for the duty count and turns active for the rest of the period. Software reaches the block through a simple single-cycle register bus, with separate write and read strobes and combinational read data.

Software sets up a channel while it is stopped and then starts it through a global enable register. Once the channel is running, software changes the waveform through a per-channel update register. A value written there is held back until the running period ends. A bit in the channel's mode register chooses whether the held value lands in the duty or the period register. Each completed period raises a flag in an interrupt status register, and reading that register clears every flag. A stop request does not take effect at once: the channel finishes its current period before its status bit drops, so software polls the status register.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every output is low, the status and interrupt status registers read zero and `irq` is low.
- R2: A running channel advances one tick every 2^N clocks, where N is mode bits [3:0] and any value above 10 counts as 10. The output is inactive while the tick count within the period is below the duty value and active otherwise. The period is the period value in ticks.
- R3: Mode bit 9 set makes the active level low and the inactive level high. A stopped channel drives its inactive level.
- R4: A duty value of zero keeps the output active for the whole period. A duty value equal to or above the period keeps it inactive, with no pulse at the period boundary.
- R5: With mode bit 10 clear, a write to the update register (bank offset 0x10) replaces the duty value only at the first period boundary after the write.
- R6: With mode bit 10 set, a write to the update register replaces the period value only at the first period boundary after the write, and the new period starts counting there.
- R7: Each period boundary sets the channel's bit (bit index = channel) in the interrupt status register at 0x01C. A read of that register returns all bits and clears them, and `irq` is high while any bit is set.
- R8: A one written to bit c of the enable register (0x004) or of the disable register (0x008) acts only on channel c. The status register at 0x00C shows one running bit per channel in bit c.
- R9: After a disable write, the channel's status bit and its waveform continue up to the first period boundary after the write. At that boundary the status bit clears and the output goes to its inactive level.
- R10: Mode, duty and period read back on their offsets 0x00, 0x04 and 0x08. The mode register keeps only bits [3:0], 9 and 10. For duty, period and update writes only the low 16 bits count, and the upper bits read as zero.
- R11: Enabling a stopped channel restarts its tick counter and prescaler from zero, so the new waveform begins at its inactive phase.
- R12: Channel c's bank starts at 0x200 + 0x20*c, and writes to one bank do not change another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; a read of the interrupt status clears it on the edge |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data, zero when no read is strobed |
| pwm_out | output | NCH (4) | One modulated output per channel |
| irq | output | 1 | High while any interrupt status bit is set |

## Verification
The bench builds the block with its defaults: four channels, 16-bit counts and a prescaler selector that saturates at 10. With four channels, enable and disable masks can be checked for their effect on neighbours, and bank spacing is checked across every bank. Small periods and prescaler settings of 0 to 3 allow random waveforms to be compared over two full periods. A selector of 15 reaches the saturation at 10, which gives ticks of 1024 clocks. Update and disable writes are placed at random cycles, so they fall at different points relative to the period boundary.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int PSC_MAX    = 10;
  localparam int PSC_SEL_W  = 4;
  localparam int OFS_ENABLE = 'h004;
  localparam int OFS_DISABLE= 'h008;
  localparam int OFS_STATUS = 'h00C;
  localparam int OFS_ISR    = 'h01C;
  localparam int OFS_BANK0  = 'h200;
  localparam int BANK_SHIFT = 5;
  localparam int REG_MODE   = 'h00;
  localparam int REG_DUTY   = 'h04;
  localparam int REG_PERIOD = 'h08;
  localparam int REG_UPD    = 'h10;
  localparam int MODE_POL   = 9;
  localparam int MODE_TGT   = 10;

  typedef struct packed {
    logic                 tgt_period;
    logic                 pol;
    logic [PSC_SEL_W-1:0] psc_sel;
  } chan_mode_t;
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
  parameter int DIV_W = 10,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d, mask;
  logic [SEL_W-1:0] sel_eff;
  logic             div_en;

  always_comb begin
    sel_eff = (sel > SEL_W'(DIV_W)) ? SEL_W'(DIV_W) : sel;
    mask    = ~({DIV_W{1'b1}} << sel_eff);
    tick    = run & (&(div_q | ~mask));
    div_en  = restart | run;
    div_d   = restart ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              wr_mode,
  input  logic              wr_duty,
  input  logic              wr_period,
  input  logic              wr_upd,
  input  logic [DATA_W-1:0] wdata,
  output logic              active_o,
  output logic              wrap_o,
  output logic              pol_o,
  output logic              pwm_o,
  output logic [DATA_W-1:0] rd_mode,
  output logic [DATA_W-1:0] rd_duty,
  output logic [DATA_W-1:0] rd_period
);
  chan_mode_t       mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, duty_q, duty_d, per_q, per_d;
  logic [CNT_W-1:0] pend_q, pend_d, last;
  logic             act_q, act_d, stop_q, stop_d, pv_q, pv_d, ptgt_q, ptgt_d;
  logic             tick, start, wrap, cnt_en, cfg_en, unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:CNT_W], wdata[8:PSC_SEL_W]};
  assign start = en_req & ~act_q;

  pwm_prescale #(.DIV_W(PSC_MAX), .SEL_W(PSC_SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(act_q), .restart(start),
    .sel(mode_q.psc_sel), .tick(tick)
  );

  always_comb begin
    last   = (per_q == '0) ? '0 : per_q - 1'b1;
    wrap   = act_q & tick & (cnt_q >= last);
    cnt_en = start | (act_q & tick);
    cnt_d  = (start | wrap) ? '0 : cnt_q + 1'b1;
    act_d  = start ? 1'b1 : ((wrap & stop_q) ? 1'b0 : act_q);
    if (start | (wrap & stop_q)) stop_d = 1'b0;
    else if (dis_req & act_q)    stop_d = 1'b1;
    else                         stop_d = stop_q;
    pv_d   = wr_upd ? 1'b1 : (wrap ? 1'b0 : pv_q);
    pend_d = wr_upd ? wdata[CNT_W-1:0] : pend_q;
    ptgt_d = wr_upd ? mode_q.tgt_period : ptgt_q;
    duty_d = duty_q;
    per_d  = per_q;
    if (wrap & pv_q) begin
      if (ptgt_q) per_d  = pend_q;
      else        duty_d = pend_q;
    end
    if (wr_duty)   duty_d = wdata[CNT_W-1:0];
    if (wr_period) per_d  = wdata[CNT_W-1:0];
    mode_d = wr_mode ? {wdata[MODE_TGT], wdata[MODE_POL], wdata[PSC_SEL_W-1:0]} : mode_q;
    cfg_en = wr_mode | wr_duty | wr_period | wr_upd | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      stop_q <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      ptgt_q <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      duty_q <= duty_d;
      per_q  <= per_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      ptgt_q <= ptgt_d;
    end
  end

  assign active_o = act_q;
  assign wrap_o   = wrap;
  assign pol_o    = mode_q.pol;
  assign pwm_o    = (act_q & (cnt_q >= duty_q)) ^ mode_q.pol;

  always_comb begin
    rd_mode                      = '0;
    rd_mode[PSC_SEL_W-1:0]       = mode_q.psc_sel;
    rd_mode[MODE_POL]            = mode_q.pol;
    rd_mode[MODE_TGT]            = mode_q.tgt_period;
    rd_duty                      = DATA_W'(duty_q);
    rd_period                    = DATA_W'(per_q);
  end
endmodule

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFS_ISR);
  localparam logic [ADDR_W-1:0] A_BANK = ADDR_W'(OFS_BANK0);

  logic [1:0]              rs_q;
  logic                    rst_int_n;
  logic [NCH-1:0]          act_vec, wrap_vec, pol_vec, isr_q, isr_d, sel_ch;
  logic [ADDR_W-1:0]       bank_rel, bank_num;
  logic [BANK_SHIFT-1:0]   reg_ofs;
  logic                    in_bank, wr_en, wr_dis, isr_clr, isr_en;
  logic [DATA_W-1:0]       rdata_d;
  logic [DATA_W-1:0]       rd_mode_a [NCH];
  logic [DATA_W-1:0]       rd_duty_a [NCH];
  logic [DATA_W-1:0]       rd_per_a  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    bank_rel = bus_addr - A_BANK;
    bank_num = bank_rel >> BANK_SHIFT;
    reg_ofs  = bank_rel[BANK_SHIFT-1:0];
    in_bank  = (bus_addr >= A_BANK);
    wr_en    = bus_wr & (bus_addr == A_EN);
    wr_dis   = bus_wr & (bus_addr == A_DIS);
    isr_clr  = bus_rd & (bus_addr == A_ISR);
    isr_d    = (isr_clr ? '0 : isr_q) | wrap_vec;
    isr_en   = isr_clr | (|wrap_vec);
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign sel_ch[c] = in_bank & (bank_num == ADDR_W'(c));
      pwm_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
        .clk(clk), .rst_n(rst_int_n),
        .en_req(wr_en & bus_wdata[c]),
        .dis_req(wr_dis & bus_wdata[c]),
        .wr_mode(bus_wr & sel_ch[c] & (reg_ofs == BANK_SHIFT'(REG_MODE))),
        .wr_duty(bus_wr & sel_ch[c] & (reg_ofs == BANK_SHIFT'(REG_DUTY))),
        .wr_period(bus_wr & sel_ch[c] & (reg_ofs == BANK_SHIFT'(REG_PERIOD))),
        .wr_upd(bus_wr & sel_ch[c] & (reg_ofs == BANK_SHIFT'(REG_UPD))),
        .wdata(bus_wdata),
        .active_o(act_vec[c]), .wrap_o(wrap_vec[c]), .pol_o(pol_vec[c]),
        .pwm_o(pwm_out[c]),
        .rd_mode(rd_mode_a[c]), .rd_duty(rd_duty_a[c]), .rd_period(rd_per_a[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  always_comb begin
    rdata_d = '0;
    if (bus_addr == A_STAT)     rdata_d = DATA_W'(act_vec);
    else if (bus_addr == A_ISR) rdata_d = DATA_W'(isr_q);
    for (int i = 0; i < NCH; i++) begin
      if (sel_ch[i]) begin
        case (reg_ofs)
          BANK_SHIFT'(REG_MODE):   rdata_d = rd_mode_a[i];
          BANK_SHIFT'(REG_DUTY):   rdata_d = rd_duty_a[i];
          BANK_SHIFT'(REG_PERIOD): rdata_d = rd_per_a[i];
          default:                 ;
        endcase
      end
    end
  end

  assign bus_rdata = bus_rd ? rdata_d : '0;
  assign irq       = |isr_q;
endmodule

// File: rtl/pwm_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] act,
  input logic [NCH-1:0] wrap,
  input logic [NCH-1:0] isr,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] pwm_out
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      assert_isr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> isr[i]);
      assert_isr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[i]) |-> $past(wrap[i]));
      assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act[i]) |-> $past(wrap[i]));
      assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !act[i] |-> (pwm_out[i] == pol[i]));
    end
  endgenerate
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NCH(NCH)) i_pwm_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .act(act_vec), .wrap(wrap_vec),
  .isr(isr_q), .pol(pol_vec), .pwm_out(pwm_out)
);

// File: tb/test_pwm_ctrl.sv
`timescale 1ns/1ps
module test_pwm_ctrl;
  logic        clk;
  logic        rst_n;
  logic        b_wr, b_rd;
  logic [11:0] b_addr;
  logic [31:0] b_wdata, b_rdata;
  logic [3:0]  pwm_out;
  logic        irq;
  int          n_run, n_fail;

  pwm_ctrl i_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [11:0] ch_addr(input int c, input int ofs);
    return 12'(32'h200 + c * 32 + ofs);
  endfunction

  function automatic logic exp_lvl(input int k, input int kb, input int n,
                                   input int p1, input int d1, input int p2,
                                   input int d2, input logic pol);
    int ticks, pos, p, d;
    if (k < kb) begin ticks = k >> n; p = p1; d = d1; end
    else begin ticks = (k - kb) >> n; p = p2; d = d2; end
    pos = (p == 0) ? 0 : ticks % p;
    return (pos >= d) ^ pol;
  endfunction

  function automatic int next_bnd(input int kw, input int n, input int p);
    int len;
    len = ((p == 0) ? 1 : p) << n;
    return (kw / len + 1) * len;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    b_rd = 1'b1; b_addr = a;
    #1 d = b_rdata;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  task automatic stop_chan(input int c);
    logic [31:0] s;
    bus_write(12'h008, 32'(1 << c));
    for (int i = 0; i < 5000; i++) begin
      bus_read(12'h00C, s);
      if (!s[c]) break;
    end
  endtask

  task automatic run_trial(input string tag, input int c, input int nf, input int ne,
                           input int p, input int d, input logic pol);
    int bad, win;
    bad = 0;
    bus_write(ch_addr(c, 0), 32'(nf) | (32'(pol) << 9));
    bus_write(ch_addr(c, 4), 32'(d));
    bus_write(ch_addr(c, 8), 32'(p));
    check({tag, " idle before start"}, 32'(pwm_out[c]), 32'(pol));
    bus_write(12'h004, 32'(1 << c));
    win = 2 * (p << ne) + 3;
    for (int k = 0; k < win; k++) begin
      if (pwm_out[c] !== exp_lvl(k, 1 << 30, ne, p, d, p, d, pol)) bad++;
      @(negedge clk);
    end
    check({tag, " waveform mismatches"}, 32'(bad), 32'd0);
    stop_chan(c);
    check({tag, " idle after stop"}, 32'(pwm_out[c]), 32'(pol));
  endtask

  task automatic run_update(input string tag, input int c, input int n, input int p,
                            input int d, input logic tgt, input int nv, input int wk);
    int bad, k, kw, kb, p2, d2;
    logic [31:0] s;
    bad = 0;
    bus_write(ch_addr(c, 0), 32'(n) | (32'(tgt) << 10));
    bus_write(ch_addr(c, 4), 32'(d));
    bus_write(ch_addr(c, 8), 32'(p));
    bus_write(12'h004, 32'(1 << c));
    k = 0;
    while (k < wk) begin
      if (pwm_out[c] !== exp_lvl(k, 1 << 30, n, p, d, p, d, 1'b0)) bad++;
      @(negedge clk); k++;
    end
    bus_write(ch_addr(c, 16), 32'h5A5A_0000 | 32'(nv));
    k++; kw = k; kb = next_bnd(kw, n, p);
    p2 = tgt ? nv : p;
    d2 = tgt ? d : nv;
    while (k < kb + 2 * (p2 << n) + 2) begin
      if (pwm_out[c] !== exp_lvl(k, kb, n, p, d, p2, d2, 1'b0)) bad++;
      @(negedge clk); k++;
    end
    check({tag, " deferred update waveform mismatches"}, 32'(bad), 32'd0);
    stop_chan(c);
    bus_read(ch_addr(c, tgt ? 8 : 4), s);
    check({tag, " live value after boundary"}, s, 32'(nv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int k, kw, kb, bad, c, n, p, d, wk;
    logic pol;
    n_run = 0; n_fail = 0;
    b_wr = 0; b_rd = 0; b_addr = '0; b_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 outputs", 32'(pwm_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    bus_read(12'h00C, s); check("R1 status", s, 32'h0);
    bus_read(12'h01C, s); check("R1 isr", s, 32'h0);

    // R10 field masking
    bus_write(ch_addr(2, 0), 32'hFFFF_FFFF);
    bus_read(ch_addr(2, 0), s); check("R10 mode keeps bits 10,9,3:0", s, 32'h0000_060F);
    bus_write(ch_addr(2, 4), 32'hDEAD_0123);
    bus_read(ch_addr(2, 4), s); check("R10 duty upper bits ignored", s, 32'h0000_0123);
    bus_write(ch_addr(2, 0), 32'h0);

    // R12 bank spacing
    for (int i = 0; i < 4; i++) bus_write(ch_addr(i, 8), 32'h1110 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      bus_read(ch_addr(i, 8), s); check("R12 per-bank period", s, 32'h1110 + 32'(i));
    end

    // R2 random waveforms (random polarity covers R3 too)
    for (int t = 0; t < 6; t++) begin
      c = int'($urandom % 4); n = int'($urandom % 4);
      p = 2 + int'($urandom % 11); d = int'($urandom % (p + 1));
      pol = 1'($urandom % 2);
      run_trial("R2 random", c, n, n, p, d, pol);
    end
    run_trial("R3 inverted polarity", 0, 1, 1, 5, 2, 1'b1);
    run_trial("R4 duty zero", 1, 1, 1, 5, 0, 1'b0);
    run_trial("R4 duty equals period", 2, 0, 0, 6, 6, 1'b0);
    run_trial("R4 duty above period", 3, 2, 2, 4, 7, 1'b0);
    run_trial("R2 prescaler saturates", 1, 15, 10, 2, 1, 1'b0);
    run_trial("R11 first start", 2, 2, 2, 5, 3, 1'b0);
    run_trial("R11 restart from zero", 2, 1, 1, 7, 4, 1'b0);

    // R5 / R6 deferred updates at random write points
    wk = 1 + int'($urandom % 20);
    run_update("R5 duty via update", 1, 0, 8, 2, 1'b0, 6, wk);
    wk = 1 + int'($urandom % 20);
    run_update("R5 duty via update prescaled", 3, 1, 5, 4, 1'b0, 1, wk);
    wk = 1 + int'($urandom % 20);
    run_update("R6 period via update", 0, 1, 4, 2, 1'b1, 9, wk);

    // R9 disable completes at the period boundary
    bus_write(ch_addr(3, 0), 32'd1);
    bus_write(ch_addr(3, 4), 32'd2);
    bus_write(ch_addr(3, 8), 32'd6);
    bus_write(12'h004, 32'h8);
    wk = 3 + int'($urandom % 18);
    for (k = 0; k < wk; k++) @(negedge clk);
    bus_write(12'h008, 32'h8);
    k++; kw = k; kb = next_bnd(kw, 1, 6); bad = 0;
    while (k < kb + 3) begin
      if (pwm_out[3] !== ((k < kb) ? exp_lvl(k, 1 << 30, 1, 6, 2, 6, 2, 1'b0) : 1'b0)) bad++;
      bus_read(12'h00C, s);
      if (s[3] !== (k < kb)) bad++;
      k++;
    end
    check("R9 status and output until boundary", 32'(bad), 32'd0);

    // R8 per-channel enable and disable
    for (int i = 0; i < 4; i++) begin
      bus_write(ch_addr(i, 0), 32'd0); bus_write(ch_addr(i, 8), 32'd5);
    end
    bus_write(12'h004, 32'h5);
    bus_read(12'h00C, s); check("R8 enable 0 and 2", s, 32'h5);
    bus_write(12'h004, 32'h2);
    bus_read(12'h00C, s); check("R8 enable 1 keeps others", s, 32'h7);
    stop_chan(2);
    bus_read(12'h00C, s); check("R8 disable 2 only", s, 32'h3);
    stop_chan(0); stop_chan(1);
    bus_read(12'h00C, s); check("R8 all stopped", s, 32'h0);

    // R7 interrupt status
    bus_read(12'h01C, s);
    bus_read(12'h01C, s); check("R7 cleared after read", s, 32'h0);
    bus_write(ch_addr(0, 8), 32'd3);
    bus_write(12'h004, 32'h1);
    repeat (10) @(negedge clk);
    check("R7 irq raised", 32'(irq), 32'h1);
    stop_chan(0);
    bus_read(12'h01C, s); check("R7 isr bit of channel 0", s, 32'h1);
    bus_read(12'h01C, s); check("R7 isr clears on read", s, 32'h0);
    check("R7 irq low after clear", 32'(irq), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule